// File: doc/BRIEF.md
# Line Signal Detect Qualifier

This block decides whether a usable signal is present on a receive line. A line slicer gives it a one-cycle strobe for each valid line pulse. In the low-speed mode it also receives a flag that says whether coded data is still arriving. From these inputs the block holds a registered detect flag.

The detect flag drives three other outputs:
- a threshold select, which moves the slicer from the squelched level to the lower unsquelched level;
- a release signal for the adaptive receive loops;
- a reference select, which tells clock recovery to follow the received data instead of the local transmit clock.

Acquisition needs two pulses that arrive close together. An isolated noise pulse expires and leaves no trace. The block leaves the detected state by one of two rules, chosen by the mode input:
- **Fast mode:** a fixed idle timeout, which restarts on every pulse.
- **Slow mode:** the loss of the data-present flag.

Top module: `line_sig_qual`

## Requirements
- R1: While reset is held and after it is released, sig_det_o, thr_low_o, release_o and ref_rx_o are 0, and the pulse count is zero. The zero pulse count is seen as: a single pulse after reset does not assert detect.
- R2: In the squelched state, a pulse that follows an earlier pulse after at most TIMEOUT_CYC-1 idle cycles sets sig_det_o to 1 at the clock edge that samples it. This rule applies in both modes.
- R3: A lone pulse never asserts detect. If TIMEOUT_CYC or more idle cycles follow a pulse while squelched, the count clears, and the next pulse counts as a first pulse.
- R4: thr_low_o (1 = unsquelch level, 0 = squelch level) and release_o are 1 exactly when sig_det_o is 1. They rise and fall in the same cycle as sig_det_o.
- R5: ref_rx_o (1 = received data, 0 = local transmit clock) equals sig_det_o in every cycle.
- R6: With mode_fast_i=1, detect stays high while the line is idle for up to TIMEOUT_CYC-1 consecutive cycles. It falls at the edge that ends the TIMEOUT_CYC-th consecutive idle cycle. Every pulse restarts the idle count.
- R7: With mode_fast_i=0, detect falls at the edge that samples manch_i=0, whatever the pulse activity. While manch_i=1, detect holds however long the line is idle.
- R8: After detect falls, the block is squelched with a zero pulse count. Reacquisition needs two fresh pulses under the R2 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_fast_i | input | 1 | 1 = fast line rate (idle timeout), 0 = slow line rate (data-present loss) |
| pulse_i | input | 1 | One valid line pulse seen this cycle |
| manch_i | input | 1 | Coded data present (used in slow mode) |
| sig_det_o | output | 1 | Registered signal detect |
| thr_low_o | output | 1 | Threshold select, 1 = unsquelch level |
| release_o | output | 1 | Release for the adaptive receive loops |
| ref_rx_o | output | 1 | Clock recovery reference, 1 = received data |

## Verification
The bench builds the block with TIMEOUT_CYC=6 instead of 150. With that value, every gap from 0 to 12 idle cycles, in both modes, can be swept exhaustively. Each sweep passes the exact boundary between gap 5, which acquires, and gap 6, which does not. The fast-mode loss sweep counts idle cycles one by one past the timeout edge. The slow-mode runs hold the line idle for longer than the timeout, to show that the timer plays no part in that mode.

// File: rtl/line_sig_qual_pkg.sv
package line_sig_qual_pkg;
  typedef enum logic {
    SQ_ST  = 1'b0,
    DET_ST = 1'b1
  } qual_st_e;
endpackage

// File: rtl/lsq_idle_timer.sv
module lsq_idle_timer #(
  parameter int unsigned TIMEOUT_CYC = 150,
  localparam int unsigned TW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic expire_o
);
  logic [TW-1:0] tmr_q;

  assign expire_o = run_i && !restart_i && (tmr_q == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tmr_q <= '0;
    else if (restart_i || !run_i || expire_o) tmr_q <= '0;
    else                                  tmr_q <= tmr_q + 1'b1;
  end
endmodule

// File: rtl/lsq_pulse_acc.sv
module lsq_pulse_acc #(
  parameter int unsigned ACQ_PULSES = 2,
  localparam int unsigned CW = $clog2(ACQ_PULSES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic pulse_i,
  input  logic clear_i,
  output logic armed_o,
  output logic hit_o
);
  logic [CW-1:0] cnt_q;

  assign armed_o = (cnt_q != '0);
  assign hit_o   = enable_i && pulse_i && (cnt_q == CW'(ACQ_PULSES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clear_i || hit_o || !enable_i) cnt_q <= '0;
    else if (pulse_i)                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lsq_fsm.sv
module lsq_fsm
  import line_sig_qual_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_fast_i,
  input  logic     manch_i,
  input  logic     acq_hit_i,
  input  logic     expire_i,
  output qual_st_e st_o
);
  qual_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SQ_ST:  if (acq_hit_i) st_d = DET_ST;
      DET_ST: begin
        if (mode_fast_i) begin
          if (expire_i) st_d = SQ_ST;
        end else if (!manch_i) begin
          st_d = SQ_ST;
        end
      end
      default: st_d = SQ_ST;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SQ_ST;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/line_sig_qual.sv
module line_sig_qual
  import line_sig_qual_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 150,
  parameter int unsigned ACQ_PULSES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_fast_i,
  input  logic pulse_i,
  input  logic manch_i,
  output logic sig_det_o,
  output logic thr_low_o,
  output logic release_o,
  output logic ref_rx_o
);
  qual_st_e st;
  logic in_sq, armed, hit, expire, tmr_run;

  assign in_sq   = (st == SQ_ST);
  // window runs while acquiring, or while holding detect at the fast rate
  assign tmr_run = (in_sq && armed) || (!in_sq && mode_fast_i);

  lsq_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (tmr_run),
    .restart_i(pulse_i),
    .expire_o (expire)
  );

  lsq_pulse_acc #(.ACQ_PULSES(ACQ_PULSES)) i_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(in_sq),
    .pulse_i (pulse_i),
    .clear_i (expire),
    .armed_o (armed),
    .hit_o   (hit)
  );

  lsq_fsm i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_fast_i(mode_fast_i),
    .manch_i    (manch_i),
    .acq_hit_i  (hit),
    .expire_i   (expire),
    .st_o       (st)
  );

  assign sig_det_o = (st == DET_ST);
  assign thr_low_o = sig_det_o;
  assign release_o = sig_det_o;
  assign ref_rx_o  = sig_det_o;
endmodule

// File: rtl/line_sig_qual_chk.sv
module line_sig_qual_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mode_fast_i,
  input logic pulse_i,
  input logic manch_i,
  input logic sig_det_o,
  input logic thr_low_o,
  input logic release_o,
  input logic ref_rx_o
);
  // R2
  det_rise_on_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sig_det_o) |-> $past(pulse_i));
  // R4
  thr_follows_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_low_o == sig_det_o) && (release_o == sig_det_o));
  // R5
  ref_follows_det_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_rx_o == sig_det_o);
  // R6
  fast_pulse_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_det_o && mode_fast_i && pulse_i) |=> sig_det_o);
  // R7
  slow_loss_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_det_o && !mode_fast_i && !manch_i) |=> !sig_det_o);
  // R7
  slow_data_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sig_det_o && !mode_fast_i && manch_i) |=> sig_det_o);
endmodule

bind line_sig_qual line_sig_qual_chk i_chk (.*);

// File: tb/test_line_sig_qual.sv
module test_line_sig_qual;
  localparam int CLK_PER = 8;
  localparam int T = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast = 1'b1, pulse = 1'b0, manch = 1'b0;
  logic det, thr, rel, refx;
  int errors = 0, checks = 0;

  always #(CLK_PER/2) clk = ~clk;

  line_sig_qual #(.TIMEOUT_CYC(T), .ACQ_PULSES(2)) i_line_sig_qual (
    .clk_i(clk), .rst_ni(rst_n), .mode_fast_i(fast), .pulse_i(pulse),
    .manch_i(manch), .sig_det_o(det), .thr_low_o(thr), .release_o(rel),
    .ref_rx_o(refx)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req, input logic exp);
    chk(req, det, exp);
    chk({req, "/R4 thr"}, thr, exp);
    chk({req, "/R4 rel"}, rel, exp);
    chk({req, "/R5 ref"}, refx, exp);
  endtask

  // drive one cycle, then settle after the edge
  task automatic cyc(input logic p, input logic m);
    @(negedge clk);
    pulse = p; manch = m;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; pulse = 1'b0; manch = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PER * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #(CLK_PER * 3);
    chk_all("R1 in reset", 1'b0);
    rst_n = 1'b1;
    #(CLK_PER);
    chk_all("R1 after reset", 1'b0);
    cyc(1'b1, 1'b0);
    chk("R1 single pulse", det, 1'b0);

    // R2/R3 acquisition sweep, both modes
    for (int md = 0; md < 2; md++) begin
      for (int g = 0; g <= 2 * T; g++) begin
        fast = md[0];
        do_reset();
        cyc(1'b1, 1'b1);
        chk("R3 first pulse", det, 1'b0);
        for (int k = 0; k < g; k++) cyc(1'b0, 1'b1);
        chk("R3 idle gap", det, 1'b0);
        cyc(1'b1, 1'b1);
        chk_all(g <= T - 1 ? "R2 acquire" : "R3 expired", g <= T - 1);
        if (g >= T) begin
          cyc(1'b1, 1'b1);
          chk("R3 fresh pair", det, 1'b1);
        end
      end
    end

    // R6 fast loss sweep with pulse restart at varying points
    fast = 1'b1;
    for (int r = 0; r < T; r++) begin
      do_reset();
      cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
      for (int k = 0; k < r; k++) cyc(1'b0, 1'b0);
      cyc(1'b1, 1'b0);
      chk("R6 restart", det, 1'b1);
      for (int k = 1; k <= T + 2; k++) begin
        cyc(1'b0, 1'b0);
        chk_all("R6 idle", k < T);
      end
      // R8 one pulse after loss is not enough
      cyc(1'b1, 1'b0);
      chk("R8 one pulse", det, 1'b0);
      cyc(1'b1, 1'b0);
      chk("R8 reacquire", det, 1'b1);
    end

    // R7 slow mode: data flag rules, timer has no effect
    fast = 1'b0;
    for (int h = 0; h <= 2 * T; h++) begin
      do_reset();
      cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
      for (int k = 0; k < h; k++) begin
        cyc(1'b0, 1'b1);
        chk("R7 hold", det, 1'b1);
      end
      cyc(h[0], 1'b0);
      chk_all("R7 loss", 1'b0);
      cyc(1'b1, 1'b1);
      chk("R8 one pulse", det, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule